// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Flag

This unit takes two operands and an opcode and returns a result clamped to the representable range of the chosen operation. It covers signed add and subtract, signed doubling, unsigned add and subtract, and saturation to a run-time bit count. That last group comes in signed and unsigned forms and works either on the whole word or on two halfwords side by side. The result path is combinational from the inputs.

Whenever an operation clamps its result, a single sticky flag is set on the next clock edge. The flag stays set until the clear input is driven high. The clear wins over a set arriving in the same cycle. A datapath uses the unit for fixed-point arithmetic and reads the flag after a run of operations to learn whether any of them overflowed.

Top module: `sat_arith_unit`

## Requirements
- R1: Opcode 0 (signed add). When both operands share a sign and the wrapped sum has the other sign, the result clamps: to the largest positive value if operand A is non-negative, otherwise to the most negative value. Otherwise the result is the wrapped sum.
- R2: Opcode 1 (signed subtract A minus B). When the operand signs differ and the wrapped difference has a sign different from A, the result clamps with the same rule as R1. Otherwise the result is the wrapped difference.
- R3: Opcode 2 (signed doubling of A). If A is at least one quarter of the word range (2^(W-2)), the result is the largest positive value. If A is at most minus that amount, the result is the most negative value, and this case counts as a clamp even at exactly -2^(W-2). Otherwise the result is A shifted left by one.
- R4: Opcode 3 (unsigned add) clamps a carry-out to all ones. Opcode 4 (unsigned subtract) clamps a borrow to zero. Otherwise each returns the wrapped value.
- R5: Opcode 5 (signed word saturation to n, where n = sat_n taken as at most W-1) limits A, read as signed, to the range -2^n to 2^n-1.
- R6: Opcode 6 (unsigned word saturation to n) sends negative A to 0 and sends A above 2^n-1 to 2^n-1.
- R7: Opcodes 7 (signed) and 8 (unsigned) apply the R5 and R6 rules to each sign-extended W/2-bit half of A on its own. Each half's result goes back into the same half of the output.
- R8: A clamp in any operation, or in either half, sets sat_flag at the next rising clock edge. A cycle without a clamp leaves the flag unchanged.
- R9: sat_flag is 0 after reset. A high flag_clr makes the flag 0 at the next edge, even when a clamp happens in the same cycle.
- R10: Opcodes 9 to 15 give a result of 0 and never count as a clamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Operation select (see R1 to R10) |
| opa | input | W | Operand A |
| opb | input | W | Operand B (add and subtract only) |
| sat_n | input | $clog2(W) | Saturation bit count for opcodes 5 to 8 |
| flag_clr | input | 1 | Clears the sticky flag |
| result | output | W | Combinational result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench builds the unit with W = 6, which makes 3-bit halves and a 3-bit sat_n. At that width every operand pair of the five add, subtract and doubling operations can be swept in full. Every operand and every legal bit count of the four width-saturation opcodes can be swept too. That puts each overflow boundary in reach, including the exact -2^(W-2) doubling case and the clamp of a single half while the other passes. The flag is predicted cycle by cycle from the expected clamps while a periodic clear is applied, so clear-against-set collisions occur throughout the sweep.

// File: rtl/sat_arith_pkg.sv
`timescale 1ns/1ps
package sat_arith_pkg;
  typedef enum logic [3:0] {
    OP_SADD  = 4'd0,
    OP_SSUB  = 4'd1,
    OP_SDBL  = 4'd2,
    OP_UADD  = 4'd3,
    OP_USUB  = 4'd4,
    OP_SSATW = 4'd5,
    OP_USATW = 4'd6,
    OP_SSATH = 4'd7,
    OP_USATH = 4'd8
  } sat_op_e;

  localparam logic [3:0] OP_LAST = 4'd8;
endpackage

// File: rtl/sat_addsub.sv
`timescale 1ns/1ps
module sat_addsub
  import sat_arith_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         hit
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] QPOS = {2'b01, {(W-2){1'b0}}};
  localparam logic [W-1:0] QNEG = {2'b11, {(W-2){1'b0}}};

  // each returns {clamp, value}
  function automatic logic [W:0] f_sadd(input logic [W-1:0] x, input logic [W-1:0] z);
    logic [W-1:0] s;
    s = x + z;
    if ((x[W-1] == z[W-1]) && (s[W-1] != x[W-1]))
      return {1'b1, (x[W-1] ? MINV : MAXV)};
    return {1'b0, s};
  endfunction

  function automatic logic [W:0] f_ssub(input logic [W-1:0] x, input logic [W-1:0] z);
    logic [W-1:0] d;
    d = x - z;
    if ((x[W-1] != z[W-1]) && (d[W-1] != x[W-1]))
      return {1'b1, (x[W-1] ? MINV : MAXV)};
    return {1'b0, d};
  endfunction

  function automatic logic [W:0] f_sdbl(input logic [W-1:0] x);
    if (!x[W-1] && (x >= QPOS)) return {1'b1, MAXV};
    if (x[W-1] && (x <= QNEG))  return {1'b1, MINV};
    return {1'b0, x[W-2:0], 1'b0};
  endfunction

  function automatic logic [W:0] f_uadd(input logic [W-1:0] x, input logic [W-1:0] z);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, z};
    if (s[W]) return {1'b1, {W{1'b1}}};
    return {1'b0, s[W-1:0]};
  endfunction

  function automatic logic [W:0] f_usub(input logic [W-1:0] x, input logic [W-1:0] z);
    if (x < z) return {1'b1, {W{1'b0}}};
    return {1'b0, x - z};
  endfunction

  logic [W:0] pick;

  always_comb begin
    case (op)
      OP_SADD: pick = f_sadd(a, b);
      OP_SSUB: pick = f_ssub(a, b);
      OP_SDBL: pick = f_sdbl(a);
      OP_UADD: pick = f_uadd(a, b);
      OP_USUB: pick = f_usub(a, b);
      default: pick = '0;
    endcase
  end

  assign y   = pick[W-1:0];
  assign hit = pick[W];
endmodule

// File: rtl/sat_clamp.sv
`timescale 1ns/1ps
module sat_clamp #(
  parameter int W  = 32,
  parameter int OW = 32,
  parameter int NW = $clog2(W)
) (
  input  logic [W-1:0]  v,
  input  logic [NW-1:0] n,
  input  logic          sgn,
  output logic [OW-1:0] y,
  output logic          hit
);
  logic [W-1:0] mask;
  logic [W-1:0] top;
  logic         s_hi, s_lo, u_neg, u_over;
  logic [W-1:0] full;

  assign mask   = (W'(1) << n) - W'(1);
  assign top    = W'($signed(v) >>> n);
  assign s_hi   = !top[W-1] && (top != '0);
  assign s_lo   = top[W-1] && (top != '1);
  assign u_neg  = v[W-1];
  assign u_over = !v[W-1] && (v > mask);

  always_comb begin
    full = v;
    hit  = 1'b0;
    if (sgn) begin
      if (s_hi)      begin full = mask;  hit = 1'b1; end
      else if (s_lo) begin full = ~mask; hit = 1'b1; end
    end else begin
      if (u_neg)       begin full = '0;   hit = 1'b1; end
      else if (u_over) begin full = mask; hit = 1'b1; end
    end
  end

  assign y = full[OW-1:0];
endmodule

// File: rtl/sat_flag.sv
`timescale 1ns/1ps
module sat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (clr) flag <= 1'b0;
    else if (set) flag <= 1'b1;
  end
endmodule

// File: rtl/sat_arith_unit.sv
`timescale 1ns/1ps
module sat_arith_unit
  import sat_arith_pkg::*;
#(
  parameter int W  = 32,
  parameter int NW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    opcode,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic [NW-1:0] sat_n,
  input  logic          flag_clr,
  output logic [W-1:0]  result,
  output logic          sat_flag
);
  localparam int H = W / 2;
  localparam logic [NW-1:0] NMAX = NW'(W - 1);

  logic [NW-1:0] n_eff;
  logic          is_arith, is_word, is_half, sgn_sel;
  logic [W-1:0]  arith_y, word_y;
  logic          arith_hit, word_hit;
  logic [H-1:0]  half_y   [2];
  logic [1:0]    half_hit;
  logic          sat_hit;

  assign n_eff    = (sat_n > NMAX) ? NMAX : sat_n;
  assign is_arith = (opcode <= 4'(OP_USUB));
  assign is_word  = (opcode == 4'(OP_SSATW)) || (opcode == 4'(OP_USATW));
  assign is_half  = (opcode == 4'(OP_SSATH)) || (opcode == 4'(OP_USATH));
  assign sgn_sel  = (opcode == 4'(OP_SSATW)) || (opcode == 4'(OP_SSATH));

  sat_addsub #(.W(W)) u_arith (
    .op(opcode), .a(opa), .b(opb), .y(arith_y), .hit(arith_hit)
  );

  sat_clamp #(.W(W), .OW(W), .NW(NW)) u_word (
    .v(opa), .n(n_eff), .sgn(sgn_sel), .y(word_y), .hit(word_hit)
  );

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [W-1:0] ext;
    assign ext = {{(W-H){opa[g*H+H-1]}}, opa[g*H +: H]};
    sat_clamp #(.W(W), .OW(H), .NW(NW)) u_lane (
      .v(ext), .n(n_eff), .sgn(sgn_sel), .y(half_y[g]), .hit(half_hit[g])
    );
  end

  always_comb begin
    if (is_arith)     result = arith_y;
    else if (is_word) result = word_y;
    else if (is_half) result = {half_y[1], half_y[0]};
    else              result = '0;
  end

  assign sat_hit = (is_arith && arith_hit) || (is_word && word_hit) ||
                   (is_half && (|half_hit));

  sat_flag u_flag (
    .clk(clk), .rst_n(rst_n), .clr(flag_clr), .set(sat_hit), .flag(sat_flag)
  );
endmodule

// File: rtl/sat_arith_chk.sv
`timescale 1ns/1ps
module sat_arith_chk
  import sat_arith_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   opcode,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         flag_clr,
  input logic [W-1:0] result,
  input logic         sat_flag,
  input logic         sat_hit
);
  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |=> !sat_flag);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !flag_clr) |=> sat_flag);

  // R8
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_hit && !flag_clr) |=> sat_flag);

  // R8
  quiet_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_hit && !flag_clr) |=> (sat_flag == $past(sat_flag)));

  // R1
  sadd_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((opcode == 4'(OP_SADD)) && (opa[W-1] == opb[W-1])) |-> (result[W-1] == opa[W-1]));

  // R4
  uadd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 4'(OP_UADD)) |-> (result >= opa));

  // R4
  usub_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 4'(OP_USUB)) |-> (result <= opa));

  // R10
  unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode > OP_LAST) |-> ((result == '0) && !sat_hit));
endmodule

bind sat_arith_unit sat_arith_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .opcode(opcode), .opa(opa), .opb(opb),
  .flag_clr(flag_clr), .result(result), .sat_flag(sat_flag), .sat_hit(sat_hit)
);

// File: tb/sim_sat_arith_unit.sv
`timescale 1ns/1ps
module sim_sat_arith_unit;
  localparam int W  = 6;
  localparam int H  = 3;
  localparam int NW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    opcode = '0;
  logic [W-1:0]  opa = '0, opb = '0;
  logic [NW-1:0] sat_n = '0;
  logic          flag_clr = 1'b0;
  logic [W-1:0]  result;
  logic          sat_flag;

  int  total = 0, bad = 0, vec = 0;
  bit  exp_flag = 1'b0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  sat_arith_unit #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .opa(opa), .opb(opb),
    .sat_n(sat_n), .flag_clr(flag_clr), .result(result), .sat_flag(sat_flag)
  );

  function automatic int sx(input int v, input int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  function automatic void lim_s(input int v, input int n, output int y, output bit c);
    y = v; c = 1'b0;
    if (v > (1 << n) - 1)   begin y = (1 << n) - 1; c = 1'b1; end
    else if (v < -(1 << n)) begin y = -(1 << n);    c = 1'b1; end
  endfunction

  function automatic void lim_u(input int v, input int n, output int y, output bit c);
    y = v; c = 1'b0;
    if (v < 0)                   begin y = 0;            c = 1'b1; end
    else if (v > (1 << n) - 1)   begin y = (1 << n) - 1; c = 1'b1; end
  endfunction

  function automatic void model(input int op, input int a, input int b, input int n,
                                output int y, output bit c);
    int sa, sb, smax, smin, umax, r, yl, yh;
    bit cl, ch;
    sa = sx(a, W); sb = sx(b, W);
    smax = (1 << (W - 1)) - 1; smin = -(1 << (W - 1)); umax = (1 << W) - 1;
    c = 1'b0; r = 0;
    case (op)
      0: begin r = sa + sb; if (r > smax) begin r = smax; c = 1; end
               else if (r < smin) begin r = smin; c = 1; end end
      1: begin r = sa - sb; if (r > smax) begin r = smax; c = 1; end
               else if (r < smin) begin r = smin; c = 1; end end
      2: begin
           if (sa >= (1 << (W - 2)))       begin r = smax; c = 1; end
           else if (sa <= -(1 << (W - 2))) begin r = smin; c = 1; end
           else r = 2 * sa;
         end
      3: begin r = a + b; if (r > umax) begin r = umax; c = 1; end end
      4: begin r = a - b; if (r < 0) begin r = 0; c = 1; end end
      5: lim_s(sa, n, r, c);
      6: lim_u(sa, n, r, c);
      7, 8: begin
        if (op == 7) begin
          lim_s(sx(a & 7, H), n, yl, cl); lim_s(sx((a >> H) & 7, H), n, yh, ch);
        end else begin
          lim_u(sx(a & 7, H), n, yl, cl); lim_u(sx((a >> H) & 7, H), n, yh, ch);
        end
        r = ((yh & 7) << H) | (yl & 7);
        c = cl | ch;
      end
      default: r = 0;
    endcase
    y = r & umax;
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3, 4: return "R4";
      5: return "R5";
      6: return "R6";
      7, 8: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string rq, input int act, input int exp, input string ctx);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, ctx, act, exp);
    end
  endtask

  task automatic run_vec(input int op, input int a, input int b, input int n, input bit clr);
    int ey; bit ec;
    string ctx;
    @(negedge clk);
    opcode = 4'(op); opa = W'(a); opb = W'(b); sat_n = NW'(n); flag_clr = clr;
    #1;
    model(op, a, b, n, ey, ec);
    ctx = $sformatf("op=%0d a=%0d b=%0d n=%0d result", op, a, b, n);
    chk(tag_of(op), int'(result), ey, ctx);
    @(posedge clk);
    exp_flag = clr ? 1'b0 : (exp_flag | ec);
    #1;
    chk(clr ? "R9" : "R8", int'(sat_flag), int'(exp_flag),
        $sformatf("op=%0d a=%0d b=%0d n=%0d clr=%0d flag", op, a, b, n, clr));
    vec++;
  endtask

  initial begin
    #1ms;
    if (!done) begin
      total++; bad++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9", int'(sat_flag), 0, "flag during reset");
    chk("R1", int'(result), 0, "result for zero operands in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R9: clamp and clear together, clear must win
    run_vec(3, 63, 63, 0, 1'b0);
    run_vec(0, 31, 1, 0, 1'b1);
    // R3: exact negative quarter clamps and sets the flag
    run_vec(2, 48, 0, 0, 1'b0);
    // R10: unused codes with clamping operands, flag left as is
    run_vec(0, 0, 0, 0, 1'b1);
    for (int op = 9; op < 16; op++) run_vec(op, 63, 63, 5, 1'b0);

    // R1 R2 R3 R4: full sweep with periodic clears
    for (int op = 0; op < 5; op++)
      for (int a = 0; a < 64; a++)
        for (int b = 0; b < 64; b++)
          run_vec(op, a, b, 0, (vec % 53) == 52);

    // R5 R6 R7: every operand and bit count
    for (int op = 5; op < 9; op++)
      for (int n = 0; n < W; n++)
        for (int a = 0; a < 64; a++)
          run_vec(op, a, 0, n, (vec % 41) == 40);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule